// File: doc/BRIEF.md
# Bus Bridge Abort Diagnostic and Control Registers

This block holds the diagnostic and control registers of a bridge that carries processor and DMA accesses onto a slower peripheral bus. When the bridge aborts a peripheral access, or sees an initiator access size that differs from the peripheral's size, the block raises a sticky flag for that event. In the same cycle it takes a snapshot of the direction and privilege level of the access that caused it. Software reads the status register to find out what went wrong. The read itself clears both flags, so no separate acknowledge write is needed.

A second register controls the bridge. One bit lets the bridge clock stop while the bridge is idle. Two further bits block the abort response so that it does not reach the DMA initiator or the on-chip initiator port, one bit for each initiator. The masking and the clock enable are combinational paths from the inputs and the control register to the outputs. The register port is a simple single-cycle select/write interface, and read data is valid in the cycle of the access.

Top module: `brg_diag_regs`

## Requirements
- R1: After reset the status register (byte offset 0x1C) reads 0x0000 and the control register (byte offset 0x20) reads 0x0002: only the DMA abort mask is set.
- R2: A pulse on `evt_abort` sets status bit 0 from the next cycle on. A read of the status register returns the flag and then clears it, so the read after that returns bit 0 = 0.
- R3: A pulse on `evt_size_mis` sets status bit 1 from the next cycle on, and a status read clears it in the same way as bit 0.
- R4: In any cycle with an abort or size-mismatch event, status bit 2 takes `cur_read` (1 = read, 0 = write) and status bit 3 takes `cur_nonpriv` (1 = not supervisor, 0 = supervisor). In cycles without an event both bits hold their value, and a status read does not clear them.
- R5: An event in the same cycle as a clearing status read leaves its flag set, so the following read still shows it.
- R6: Writes to the status register have no effect on any of its bits.
- R7: Control bits 3 (power saving), 2 (on-chip port abort mask) and 1 (DMA abort mask) can be written and read back. Control bits 15:4 and bit 0 always read 0.
- R8: `dma_abort_out` equals `dma_abort_in` while control bit 1 is 0, and is 0 while that bit is 1, in the same cycle.
- R9: `ocp_abort_out` equals `ocp_abort_in` while control bit 2 is 0, and is 0 while that bit is 1, in the same cycle.
- R10: `bridge_clk_en` is 1 while control bit 3 is 0. While control bit 3 is 1 it follows `bridge_busy`.
- R11: Accesses to any other offset read 0, change no register, and do not clear the status flags.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_sel | input | 1 | Register access in this cycle |
| reg_wr | input | 1 | 1 = write, 0 = read |
| reg_addr | input | ADDR_W | Byte offset of the access |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data, valid in the access cycle |
| evt_abort | input | 1 | Peripheral access aborted (pulse) |
| evt_size_mis | input | 1 | Access size mismatch (pulse) |
| cur_read | input | 1 | Direction of the current access, 1 = read |
| cur_nonpriv | input | 1 | 1 = initiator not in supervisor mode |
| dma_abort_in | input | 1 | Abort response headed for the DMA |
| ocp_abort_in | input | 1 | Abort response headed for the on-chip port |
| bridge_busy | input | 1 | Bridge has work in progress |
| dma_abort_out | output | 1 | Abort response to the DMA after masking |
| ocp_abort_out | output | 1 | Abort response to the on-chip port after masking |
| bridge_clk_en | output | 1 | Enable for the bridge clock gate |

## Verification
An event or a register write changes state at the next rising edge. The bench therefore applies it on one falling edge and reads the result back on a later falling edge. Read data, the masked aborts and the clock enable are due in the same cycle as their inputs. The monitor compares them 1 ns after the falling edge that applied those inputs, well before the next rising edge. A clearing read shows the old flag during its own cycle, and the flag is gone by the following read. Each such pair is queued and checked in that order.

// File: rtl/brg_diag_pkg.sv
`timescale 1ns/1ps
package brg_diag_pkg;

   // status register layout, LSB first: abort, mismatch, direction, privilege
   typedef struct packed {
      logic nonpriv;
      logic rd;
      logic mis;
      logic abt;
   } stat_t;

   // writable control bits, register bits 3..1
   typedef struct packed {
      logic dps_en;
      logic ocp_mask;
      logic dma_mask;
   } ctrl_t;

   localparam int STAT_BITS = 4;
   localparam int CTRL_LSB  = 1;
   localparam int CTRL_BITS = 3;
   localparam int N_INIT    = 2;   // index 0 = DMA, 1 = on-chip port

endpackage

// File: rtl/brg_diag_decode.sv
`timescale 1ns/1ps
module brg_diag_decode #(
   parameter int ADDR_W   = 8,
   parameter int STAT_OFS = 'h1C,
   parameter int CTRL_OFS = 'h20
) (
   input  logic              reg_sel,
   input  logic              reg_wr,
   input  logic [ADDR_W-1:0] reg_addr,
   output logic              stat_hit,
   output logic              ctrl_hit,
   output logic              stat_clr,
   output logic              ctrl_we
);
   localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(STAT_OFS);
   localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_OFS);

   always_comb begin
      stat_hit = reg_sel && (reg_addr == STAT_A);
      ctrl_hit = reg_sel && (reg_addr == CTRL_A);
      stat_clr = stat_hit && !reg_wr;
      ctrl_we  = ctrl_hit && reg_wr;
   end
endmodule

// File: rtl/brg_diag_status.sv
`timescale 1ns/1ps
module brg_diag_status
   import brg_diag_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   input  logic  clr,
   input  logic  evt_abort,
   input  logic  evt_size_mis,
   input  logic  cur_read,
   input  logic  cur_nonpriv,
   output stat_t stat
);
   logic any_evt;
   assign any_evt = evt_abort | evt_size_mis;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stat <= '0;
      end else begin
         // a new event wins over the read clear
         stat.abt <= (stat.abt & ~clr) | evt_abort;
         stat.mis <= (stat.mis & ~clr) | evt_size_mis;
         if (any_evt) begin
            stat.rd      <= cur_read;
            stat.nonpriv <= cur_nonpriv;
         end
      end
   end
endmodule

// File: rtl/brg_diag_ctrl.sv
`timescale 1ns/1ps
module brg_diag_ctrl
   import brg_diag_pkg::*;
#(
   parameter bit DMA_MASK_RST = 1'b1,
   parameter bit OCP_MASK_RST = 1'b0
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 we,
   input  logic [CTRL_BITS-1:0] wbits,
   output ctrl_t                ctrl
);
   localparam ctrl_t RST_VAL = '{dps_en: 1'b0, ocp_mask: OCP_MASK_RST,
                                 dma_mask: DMA_MASK_RST};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  ctrl <= RST_VAL;
      else if (we) ctrl <= ctrl_t'(wbits);
   end
endmodule

// File: rtl/brg_diag_resp.sv
`timescale 1ns/1ps
module brg_diag_resp
   import brg_diag_pkg::*;
(
   input  ctrl_t             ctrl,
   input  logic [N_INIT-1:0] abort_in,
   input  logic              bridge_busy,
   output logic [N_INIT-1:0] abort_out,
   output logic              clk_en
);
   logic [N_INIT-1:0] mask;
   assign mask = {ctrl.ocp_mask, ctrl.dma_mask};

   for (genvar i = 0; i < N_INIT; i++) begin : g_init
      assign abort_out[i] = abort_in[i] & ~mask[i];
   end

   assign clk_en = !ctrl.dps_en || bridge_busy;
endmodule

// File: rtl/brg_diag_regs.sv
`timescale 1ns/1ps
module brg_diag_regs
   import brg_diag_pkg::*;
#(
   parameter int ADDR_W       = 8,
   parameter int DATA_W       = 16,
   parameter int STAT_OFS     = 'h1C,
   parameter int CTRL_OFS     = 'h20,
   parameter bit DMA_MASK_RST = 1'b1,
   parameter bit RD_FLOP      = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_sel,
   input  logic              reg_wr,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic              evt_abort,
   input  logic              evt_size_mis,
   input  logic              cur_read,
   input  logic              cur_nonpriv,
   input  logic              dma_abort_in,
   input  logic              ocp_abort_in,
   input  logic              bridge_busy,
   output logic              dma_abort_out,
   output logic              ocp_abort_out,
   output logic              bridge_clk_en
);
   localparam int PAD_W = DATA_W - STAT_BITS;

   if (DATA_W < STAT_BITS) begin : g_bad_w
      $error("DATA_W must hold the four status bits");
   end
   if (STAT_OFS == CTRL_OFS) begin : g_bad_ofs
      $error("register offsets must differ");
   end
   if ((STAT_OFS >> ADDR_W) != 0 || (CTRL_OFS >> ADDR_W) != 0) begin : g_bad_a
      $error("offsets do not fit in ADDR_W");
   end

   logic stat_hit, ctrl_hit, stat_clr, ctrl_we;
   stat_t stat_q;
   ctrl_t ctrl_q;
   logic [N_INIT-1:0] ab_in, ab_out;
   logic [DATA_W-1:0] rd_mux;
   logic unused_wdata;

   assign unused_wdata = ^{reg_wdata[DATA_W-1:CTRL_LSB+CTRL_BITS],
                           reg_wdata[CTRL_LSB-1:0]};

   brg_diag_decode #(.ADDR_W(ADDR_W), .STAT_OFS(STAT_OFS), .CTRL_OFS(CTRL_OFS))
      u_dec (.reg_sel(reg_sel), .reg_wr(reg_wr), .reg_addr(reg_addr),
             .stat_hit(stat_hit), .ctrl_hit(ctrl_hit),
             .stat_clr(stat_clr), .ctrl_we(ctrl_we));

   brg_diag_status u_stat (
      .clk(clk), .rst_n(rst_n), .clr(stat_clr),
      .evt_abort(evt_abort), .evt_size_mis(evt_size_mis),
      .cur_read(cur_read), .cur_nonpriv(cur_nonpriv), .stat(stat_q));

   brg_diag_ctrl #(.DMA_MASK_RST(DMA_MASK_RST), .OCP_MASK_RST(1'b0)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .we(ctrl_we),
      .wbits(reg_wdata[CTRL_LSB+CTRL_BITS-1:CTRL_LSB]), .ctrl(ctrl_q));

   assign ab_in = {ocp_abort_in, dma_abort_in};

   brg_diag_resp u_resp (
      .ctrl(ctrl_q), .abort_in(ab_in), .bridge_busy(bridge_busy),
      .abort_out(ab_out), .clk_en(bridge_clk_en));

   assign dma_abort_out = ab_out[0];
   assign ocp_abort_out = ab_out[1];

   always_comb begin
      rd_mux = '0;
      if (stat_hit)      rd_mux = {{PAD_W{1'b0}}, stat_q};
      else if (ctrl_hit) rd_mux = {{PAD_W{1'b0}}, ctrl_q, 1'b0};
   end

   if (RD_FLOP) begin : g_rd_flop
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                  reg_rdata <= '0;
         else if (reg_sel && !reg_wr) reg_rdata <= rd_mux;
      end
   end else begin : g_rd_comb
      assign reg_rdata = rd_mux;
   end
endmodule

// File: rtl/brg_diag_chk.sv
`timescale 1ns/1ps
module brg_diag_chk #(
   parameter int ADDR_W   = 8,
   parameter int DATA_W   = 16,
   parameter int STAT_OFS = 'h1C
) (
   input logic              clk,
   input logic              rst_n,
   input logic              reg_sel,
   input logic              reg_wr,
   input logic [ADDR_W-1:0] reg_addr,
   input logic [DATA_W-1:0] reg_rdata,
   input logic              evt_abort,
   input logic              evt_size_mis,
   input logic              cur_read,
   input logic              cur_nonpriv,
   input logic [3:0]        stat_q,
   input logic [2:0]        ctrl_q,
   input logic              dma_abort_out,
   input logic              ocp_abort_out,
   input logic              bridge_clk_en
);
   logic stat_acc, any_evt;
   assign stat_acc = reg_sel && (reg_addr == ADDR_W'(STAT_OFS));
   assign any_evt  = evt_abort || evt_size_mis;

   AST_ABORT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      evt_abort |=> stat_q[0]);                                          // R2
   AST_ABORT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_acc && !reg_wr && !evt_abort) |=> !stat_q[0]);               // R2
   AST_MIS_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      evt_size_mis |=> stat_q[1]);                                       // R3
   AST_SNAPSHOT: assert property (@(posedge clk) disable iff (!rst_n)
      any_evt |=> (stat_q[2] == $past(cur_read)) &&
                  (stat_q[3] == $past(cur_nonpriv)));                    // R4
   AST_SNAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !any_evt |=> stat_q[3:2] == $past(stat_q[3:2]));                   // R4
   AST_STAT_WR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_acc && reg_wr && !any_evt) |=> stat_q == $past(stat_q));     // R6
   AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      reg_rdata[DATA_W-1:4] == '0);                                      // R7
   AST_DMA_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_q[0] |-> !dma_abort_out);                                     // R8
   AST_OCP_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_q[1] |-> !ocp_abort_out);                                     // R9
   AST_CLK_ON: assert property (@(posedge clk) disable iff (!rst_n)
      !ctrl_q[2] |-> bridge_clk_en);                                     // R10
endmodule

bind brg_diag_regs brg_diag_chk #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .STAT_OFS(STAT_OFS)
) u_chk (
   .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
   .reg_addr(reg_addr), .reg_rdata(reg_rdata), .evt_abort(evt_abort),
   .evt_size_mis(evt_size_mis), .cur_read(cur_read),
   .cur_nonpriv(cur_nonpriv), .stat_q(stat_q), .ctrl_q(ctrl_q),
   .dma_abort_out(dma_abort_out), .ocp_abort_out(ocp_abort_out),
   .bridge_clk_en(bridge_clk_en));

// File: tb/brg_diag_regs_test.sv
`timescale 1ns/1ps
module brg_diag_regs_test;
   localparam int AW = 8;
   localparam int DW = 16;
   localparam logic [AW-1:0] A_ST = 8'h1C;
   localparam logic [AW-1:0] A_CT = 8'h20;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic reg_sel = 0, reg_wr = 0;
   logic [AW-1:0] reg_addr = '0;
   logic [DW-1:0] reg_wdata = '0;
   logic [DW-1:0] reg_rdata;
   logic evt_abort = 0, evt_size_mis = 0, cur_read = 0, cur_nonpriv = 0;
   logic dma_abort_in = 0, ocp_abort_in = 0, bridge_busy = 0;
   logic dma_abort_out, ocp_abort_out, bridge_clk_en;

   always #2.5 clk = ~clk;

   brg_diag_regs uut (
      .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .evt_abort(evt_abort), .evt_size_mis(evt_size_mis),
      .cur_read(cur_read), .cur_nonpriv(cur_nonpriv),
      .dma_abort_in(dma_abort_in), .ocp_abort_in(ocp_abort_in),
      .bridge_busy(bridge_busy), .dma_abort_out(dma_abort_out),
      .ocp_abort_out(ocp_abort_out), .bridge_clk_en(bridge_clk_en));

   typedef struct {
      int          kind;   // 0 = read data, 1 = {clk_en, ocp_out, dma_out}
      logic [15:0] exp;
      string       tag;
   } item_t;

   item_t sb[$];
   logic  obs = 0;
   int    n_chk = 0, n_fail = 0;
   bit    done = 0;

   task automatic quiet();
      reg_sel = 0; reg_wr = 0; reg_addr = '0; reg_wdata = '0;
      evt_abort = 0; evt_size_mis = 0; obs = 0;
   endtask

   task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
      @(negedge clk); quiet();
      reg_sel = 1; reg_wr = 1; reg_addr = a; reg_wdata = d;
   endtask

   task automatic rd(input logic [AW-1:0] a, input logic [15:0] e, input string t);
      @(negedge clk); quiet();
      reg_sel = 1; reg_addr = a; obs = 1;
      sb.push_back('{kind: 0, exp: e, tag: t});
   endtask

   task automatic evt(input logic ab, input logic mi, input logic r, input logic np);
      @(negedge clk); quiet();
      evt_abort = ab; evt_size_mis = mi; cur_read = r; cur_nonpriv = np;
   endtask

   task automatic rd_evt(input logic ab, input logic mi, input logic [15:0] e,
                         input string t);
      @(negedge clk); quiet();
      reg_sel = 1; reg_addr = A_ST; evt_abort = ab; evt_size_mis = mi; obs = 1;
      sb.push_back('{kind: 0, exp: e, tag: t});
   endtask

   task automatic outs(input logic di, input logic oi, input logic bz,
                       input logic [2:0] e, input string t);
      @(negedge clk); quiet();
      dma_abort_in = di; ocp_abort_in = oi; bridge_busy = bz; obs = 1;
      sb.push_back('{kind: 1, exp: {13'd0, e}, tag: t});
   endtask

   // monitor: compare 1 ns after the driving falling edge
   initial begin
      forever begin
         @(negedge clk); #1;
         if (obs) begin
            item_t it;
            logic [15:0] act;
            if (sb.size() == 0) begin
               n_chk++; n_fail++;
               $display("FAIL scoreboard empty: act=none exp=item");
            end else begin
               it = sb.pop_front();
               act = (it.kind == 0) ? reg_rdata
                                    : {13'd0, bridge_clk_en, ocp_abort_out, dma_abort_out};
               n_chk++;
               if (act !== it.exp) begin
                  n_fail++;
                  $display("FAIL %s: act=0x%04h exp=0x%04h", it.tag, act, it.exp);
               end
            end
         end
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: act=hung exp=finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      // R1 reset values
      rd(A_ST, 16'h0000, "R1 status reset");
      rd(A_CT, 16'h0002, "R1 control reset");
      // R8, R10 with reset control: DMA masked, clock on
      outs(1, 1, 0, 3'b110, "R8 reset dma mask");
      // R2, R4 abort on a supervisor read
      evt(1, 0, 1, 0);
      rd(A_ST, 16'h0005, "R2 abort flag set");
      rd(A_ST, 16'h0004, "R2 flag cleared, R4 snapshot kept");
      // R3, R4 mismatch on user write
      evt(0, 1, 0, 1);
      rd(A_ST, 16'h000A, "R3 mismatch flag set");
      rd(A_ST, 16'h0008, "R3 flag cleared");
      // R4 no event: snapshot holds
      evt(0, 0, 1, 0);
      rd(A_ST, 16'h0008, "R4 hold without event");
      evt(1, 1, 1, 1);
      rd(A_ST, 16'h000F, "R4 both events");
      rd(A_ST, 16'h000C, "R4 both cleared");
      // R5 event during clearing read
      evt(1, 0, 0, 0);
      rd_evt(1, 0, 16'h0001, "R5 read with event");
      rd(A_ST, 16'h0001, "R5 flag survives");
      rd(A_ST, 16'h0000, "R5 then clears");
      // R6 status writes ignored
      wr(A_ST, 16'hFFFF);
      rd(A_ST, 16'h0000, "R6 write all ones");
      evt(1, 0, 1, 1);
      wr(A_ST, 16'h0000);
      rd(A_ST, 16'h000D, "R6 write does not clear");
      rd(A_ST, 16'h000C, "R6 read clears");
      // R7 control read-back
      wr(A_CT, 16'hFFFF);
      rd(A_CT, 16'h000E, "R7 writable bits only");
      wr(A_CT, 16'h0000);
      rd(A_CT, 16'h0000, "R7 clear all");
      // R8, R9 masking
      outs(1, 1, 1, 3'b111, "R8 R9 pass through");
      wr(A_CT, 16'h0004);
      outs(1, 1, 0, 3'b101, "R9 ocp masked");
      wr(A_CT, 16'h0002);
      outs(1, 1, 0, 3'b110, "R8 dma masked");
      outs(0, 0, 0, 3'b100, "R8 no abort");
      // R10 power saving
      wr(A_CT, 16'h0008);
      outs(0, 0, 0, 3'b000, "R10 idle gated");
      outs(1, 1, 1, 3'b111, "R10 busy enabled");
      // R11 other offsets
      rd(8'h00, 16'h0000, "R11 unmapped read");
      wr(8'h24, 16'hFFFF);
      rd(A_CT, 16'h0008, "R11 unmapped write");
      evt(1, 0, 0, 0);
      rd(8'h24, 16'h0000, "R11 unmapped read 2");
      rd(A_ST, 16'h0001, "R11 flag not cleared");
      @(negedge clk); quiet();
      repeat (2) @(negedge clk);
      if (sb.size() != 0) begin
         n_chk++; n_fail++;
         $display("FAIL scoreboard leftover: act=%0d exp=0", sb.size());
      end
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule